// File: doc/BRIEF.md
# Non-Volatile Memory Write-Protection Gate

This block sits between the masters that write on-chip non-volatile memory and the memory controller. For every memory request it decides whether the access may proceed and returns a grant or a refusal. Three areas are covered: program memory, data memory and the option bytes. All writes are locked after reset. Software opens the program area or the data area by writing a two-byte key sequence to that area's key register. The option area follows the data-area lock.

A boot region at the bottom of program memory is sized in 512-byte pages by a configuration input. It stays write-locked whatever the key state. A read-out protection flag, loaded at reset from the option bytes, refuses every debug-port access to program and data memory. Clearing that flag while it is set raises a one-cycle global-erase request.

Requests enter through a valid/ready handshake and results leave through a valid/ready handshake. `req_ready` is high when the result slot is empty or is being drained in the same cycle (`!resp_valid || resp_ready`). A result is held unchanged until `resp_ready` is seen with it. The register bus, the configuration pins and the status pins are plain signals with no handshake.

Top module: `flash_wp_gate`

## Requirements
- R1: After reset both unlock status bits are 0, `rop_active` equals `rop_init`, and every write request to areas 0, 1 and 2 is refused.
- R2: Writing 0x56 and then 0xAE to register address 0 sets `prog_unlocked`, and program-area (area 0) writes outside the boot region are then granted.
- R3: Writing 0xAE and then 0x56 to register address 1 sets `data_unlocked`, and writes to the data area (1) and the option area (2) are then granted.
- R4: A key-register write carrying any byte other than the one expected next clears that area's unlock bit and restarts its sequence, so the wrong order never unlocks.
- R5: A write to register address 2 with bit 0 = 0 re-locks the program area, and one with bit 1 = 0 re-locks the data area, both at once. A 1 in either bit has no effect.
- R6: A program-area write whose offset is below `boot_pages`*512 is refused even when the program area is unlocked. With `boot_pages` of 128 or more, every program write is refused.
- R7: Reads to areas 0 to 2 are granted unless R8 applies. Every request to area 3 (reserved) is refused.
- R8: While `rop_active` is 1, every request with `req_dbg` = 1 to area 0 or 1 is refused, read or write. Requests with `req_dbg` = 0 are unaffected.
- R9: A write to register address 3 while the data area is unlocked sets the flag from bit 0. Clearing a set flag raises `erase_req` for exactly one cycle. Setting the flag raises no erase. The write is ignored while the data area is locked.
- R10: Each accepted write that is refused produces a one-cycle `viol_pulse`, in the same cycle as its result.
- R11: A result appears one cycle after its request is accepted and stays stable while `resp_ready` is 0. During that time `req_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rop_init | input | 1 | Read-out protection value loaded at reset |
| boot_pages | input | 8 | Boot region size in 512-byte pages |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 program key, 1 data key, 2 lock control, 3 read-out option |
| reg_wdata | input | 8 | Register write data |
| req_valid | input | 1 | Memory request valid |
| req_ready | output | 1 | Memory request accepted when high with valid |
| req_area | input | 2 | 0 program, 1 data, 2 option, 3 reserved |
| req_offset | input | 16 | Byte offset within the area |
| req_write | input | 1 | 1 write, 0 read |
| req_dbg | input | 1 | Request comes from the debug/programming port |
| resp_valid | output | 1 | Result valid |
| resp_ready | input | 1 | Result consumer ready |
| resp_grant | output | 1 | 1 access allowed, 0 refused |
| viol_pulse | output | 1 | One-cycle pulse for a refused write |
| erase_req | output | 1 | One-cycle global-erase request |
| prog_unlocked | output | 1 | Program area unlocked |
| data_unlocked | output | 1 | Data and option areas unlocked |
| rop_active | output | 1 | Read-out protection flag |

## Verification
Register writes change the status pins at the clock edge that samples them, so the bench reads them half a cycle after that edge. A memory result, together with its violation pulse, is due at the edge that accepts the request, one registered stage. An erase request is due at the edge of the option write. The bench drives each stimulus on the falling edge and samples at the next falling edge, after exactly one rising edge. In the back-pressure case it walks further edges and checks that the held result does not move.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
  parameter int OFFSET_W   = 16;
  parameter int PAGE_SHIFT = 9;
  parameter int PAGE_CNT_W = 8;
  parameter int KEY_W      = 8;
  parameter int NUM_KEYS   = 2;

  parameter logic [KEY_W-1:0] KEY_LO = 8'h56;
  parameter logic [KEY_W-1:0] KEY_HI = 8'hAE;

  typedef enum logic [1:0] {
    AREA_PROG = 2'd0,
    AREA_DATA = 2'd1,
    AREA_OPT  = 2'd2,
    AREA_RSV  = 2'd3
  } area_e;

  typedef enum logic [1:0] {
    RA_PKEY = 2'd0,
    RA_DKEY = 2'd1,
    RA_LOCK = 2'd2,
    RA_ROP  = 2'd3
  } regaddr_e;

  typedef enum logic {SEQ_IDLE = 1'b0, SEQ_HALF = 1'b1} seq_e;
endpackage

// File: rtl/fwp_key_unlock.sv
module fwp_key_unlock
  import fwp_pkg::*;
#(
  parameter logic [KEY_W-1:0] K_FIRST  = KEY_LO,
  parameter logic [KEY_W-1:0] K_SECOND = KEY_HI
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_we,
  input  logic [KEY_W-1:0] key_data,
  input  logic             relock,
  output logic             unlocked
);
  seq_e seq_q;
  logic unl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_q <= SEQ_IDLE;
      unl_q <= 1'b0;
    end else if (relock) begin
      seq_q <= SEQ_IDLE;
      unl_q <= 1'b0;
    end else if (key_we) begin
      if (seq_q == SEQ_IDLE && key_data == K_FIRST) begin
        seq_q <= SEQ_HALF;
      end else if (seq_q == SEQ_HALF && key_data == K_SECOND) begin
        seq_q <= SEQ_IDLE;
        unl_q <= 1'b1;
      end else begin
        seq_q <= SEQ_IDLE;
        unl_q <= 1'b0;
      end
    end
  end

  assign unlocked = unl_q;

  // R2 R3
  unlock_needs_second_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unl_q) |-> $past(key_we && key_data == K_SECOND && !relock));
  // R4
  wrong_key_relocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_we && key_data != K_FIRST && key_data != K_SECOND) |=> !unl_q);
endmodule

// File: rtl/fwp_rop_ctrl.sv
module fwp_rop_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic rop_init,
  input  logic opt_we,
  input  logic opt_val,
  output logic rop_active,
  output logic erase_req
);
  logic rop_q, erase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rop_q   <= rop_init;
      erase_q <= 1'b0;
    end else begin
      erase_q <= opt_we && rop_q && !opt_val;
      if (opt_we) rop_q <= opt_val;
    end
  end

  assign rop_active = rop_q;
  assign erase_req  = erase_q;

  // R9
  erase_only_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_q |-> $past(rop_q) && !rop_q);
  // R9
  erase_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_q |=> !erase_q);
endmodule

// File: rtl/fwp_access_judge.sv
module fwp_access_judge
  import fwp_pkg::*;
(
  input  logic [1:0]            area,
  input  logic [OFFSET_W-1:0]   offset,
  input  logic                  is_write,
  input  logic                  is_dbg,
  input  logic                  prog_unl,
  input  logic                  data_unl,
  input  logic                  rop,
  input  logic [PAGE_CNT_W-1:0] boot_pages,
  output logic                  grant
);
  localparam int IDX_W = OFFSET_W - PAGE_SHIFT;
  localparam int CMP_W = ((IDX_W > PAGE_CNT_W) ? IDX_W : PAGE_CNT_W) + 1;

  logic [CMP_W-1:0] page_idx, page_lim;
  logic in_boot, rop_block;

  assign page_idx  = CMP_W'(offset >> PAGE_SHIFT);
  assign page_lim  = CMP_W'(boot_pages);
  assign in_boot   = page_idx < page_lim;
  assign rop_block = rop && is_dbg && (area == AREA_PROG || area == AREA_DATA);

  always_comb begin
    grant = 1'b0;
    if (!rop_block) begin
      unique case (area_e'(area))
        AREA_PROG: grant = !is_write || (prog_unl && !in_boot);
        AREA_DATA,
        AREA_OPT:  grant = !is_write || data_unl;
        default:   grant = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/flash_wp_gate.sv
module flash_wp_gate
  import fwp_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rop_init,
  input  logic [PAGE_CNT_W-1:0] boot_pages,
  input  logic                  reg_we,
  input  logic [1:0]            reg_addr,
  input  logic [KEY_W-1:0]      reg_wdata,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [1:0]            req_area,
  input  logic [OFFSET_W-1:0]   req_offset,
  input  logic                  req_write,
  input  logic                  req_dbg,
  output logic                  resp_valid,
  input  logic                  resp_ready,
  output logic                  resp_grant,
  output logic                  viol_pulse,
  output logic                  erase_req,
  output logic                  prog_unlocked,
  output logic                  data_unlocked,
  output logic                  rop_active
);
  logic [NUM_KEYS-1:0] unl;
  logic [NUM_KEYS-1:0] key_we, relock;
  logic rop, grant_c, accept;
  logic rv_q, rg_q, viol_q;

  for (genvar g = 0; g < NUM_KEYS; g++) begin : g_key
    localparam logic [KEY_W-1:0] KF = (g == 0) ? KEY_LO : KEY_HI;
    localparam logic [KEY_W-1:0] KS = (g == 0) ? KEY_HI : KEY_LO;
    assign key_we[g] = reg_we && reg_addr == 2'(g);
    assign relock[g] = reg_we && reg_addr == RA_LOCK && !reg_wdata[g];
    fwp_key_unlock #(.K_FIRST(KF), .K_SECOND(KS)) u_key (
      .clk(clk), .rst_n(rst_n), .key_we(key_we[g]), .key_data(reg_wdata),
      .relock(relock[g]), .unlocked(unl[g]));
  end

  fwp_rop_ctrl u_rop (
    .clk(clk), .rst_n(rst_n), .rop_init(rop_init),
    .opt_we(reg_we && reg_addr == RA_ROP && unl[1]),
    .opt_val(reg_wdata[0]), .rop_active(rop), .erase_req(erase_req));

  fwp_access_judge u_judge (
    .area(req_area), .offset(req_offset), .is_write(req_write), .is_dbg(req_dbg),
    .prog_unl(unl[0]), .data_unl(unl[1]), .rop(rop), .boot_pages(boot_pages),
    .grant(grant_c));

  assign req_ready = !rv_q || resp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rv_q   <= 1'b0;
      rg_q   <= 1'b0;
      viol_q <= 1'b0;
    end else begin
      viol_q <= accept && req_write && !grant_c;
      if (accept) begin
        rv_q <= 1'b1;
        rg_q <= grant_c;
      end else if (resp_ready) begin
        rv_q <= 1'b0;
      end
    end
  end

  assign resp_valid    = rv_q;
  assign resp_grant    = rg_q;
  assign viol_pulse    = viol_q;
  assign prog_unlocked = unl[0];
  assign data_unlocked = unl[1];
  assign rop_active    = rop;

  // R10
  viol_matches_refusal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_q |-> rv_q && !rg_q);
  // R11
  held_result_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rv_q && !resp_ready) |=> rv_q && $stable(rg_q));
  // R6
  boot_write_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write && req_area == AREA_PROG &&
     (32'(req_offset) >> PAGE_SHIFT) < 32'(boot_pages)) |=> !rg_q);
  // R8
  rop_dbg_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && rop && req_dbg && !req_area[1]) |=> !rg_q);
  // R5
  lock_ctrl_relocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == RA_LOCK && !reg_wdata[0]) |=> !unl[0]);
endmodule

// File: tb/sim_flash_wp_gate.sv
module sim_flash_wp_gate;
  logic clk = 0, rst_n = 0, rop_init = 0;
  logic [7:0] boot_pages = 0;
  logic reg_we = 0; logic [1:0] reg_addr = 0; logic [7:0] reg_wdata = 0;
  logic req_valid = 0, req_ready; logic [1:0] req_area = 0;
  logic [15:0] req_offset = 0; logic req_write = 0, req_dbg = 0;
  logic resp_valid, resp_ready = 1, resp_grant, viol_pulse, erase_req;
  logic prog_unlocked, data_unlocked, rop_active;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  flash_wp_gate u0 (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_we = 0;
  endtask

  task automatic req(input logic [1:0] ar, input logic [15:0] off, input logic wr,
                     input logic dbg, output logic g, output logic v);
    req_valid = 1; req_area = ar; req_offset = off; req_write = wr; req_dbg = dbg;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    g = resp_grant; v = viol_pulse;
  endtask

  function automatic logic model(input logic [1:0] ar, input int off, input logic wr,
      input logic dbg, input logic pu, input logic du, input logic rop, input int pages);
    if (rop && dbg && ar < 2) return 0;
    if (ar == 3) return 0;
    if (!wr) return 1;
    if (ar == 0) return pu && ((off / 512) >= pages);
    return du;
  endfunction

  task automatic sweep(input string tag, input logic pu, input logic du, input logic rop);
    int pg[4] = '{0, 1, 3, 200};
    int of[6] = '{0, 511, 512, 1024, 1536, 65535};
    logic g, v;
    foreach (pg[p]) begin
      boot_pages = 8'(pg[p]);
      for (int ar = 0; ar < 4; ar++)
        foreach (of[o])
          for (int k = 0; k < 4; k++) begin
            logic e;
            e = model(2'(ar), of[o], k[0], k[1], pu, du, rop, pg[p]);
            req(2'(ar), 16'(of[o]), k[0], k[1], g, v);
            chk(tag, g, e);
            chk("R10", v, k[0] && !e);
          end
    end
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic g, v;
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    // R1
    chk("R1 prog", prog_unlocked, 0);
    chk("R1 data", data_unlocked, 0);
    chk("R1 rop", rop_active, 0);
    chk("R11 ready", req_ready, 1);
    sweep("R1 R7", 0, 0, 0);
    // R2
    wreg(0, 8'h56); chk("R2 half", prog_unlocked, 0);
    wreg(0, 8'hAE); chk("R2 open", prog_unlocked, 1);
    chk("R2 data stays", data_unlocked, 0);
    sweep("R2 R6", 1, 0, 0);
    // R4
    wreg(0, 8'h12); chk("R4 wrong byte", prog_unlocked, 0);
    wreg(0, 8'hAE); wreg(0, 8'h56); chk("R4 wrong order", prog_unlocked, 0);
    wreg(0, 8'h56); chk("R4 repeat first", prog_unlocked, 0);
    wreg(0, 8'h00);
    // R3
    wreg(1, 8'h56); wreg(1, 8'hAE); chk("R4 data order", data_unlocked, 0);
    wreg(1, 8'h00);
    wreg(1, 8'hAE); wreg(1, 8'h56); chk("R3 open", data_unlocked, 1);
    wreg(0, 8'h56); wreg(0, 8'hAE);
    sweep("R3 R6", 1, 1, 0);
    // R5
    wreg(2, 8'h03);
    chk("R5 ones keep p", prog_unlocked, 1); chk("R5 ones keep d", data_unlocked, 1);
    wreg(2, 8'h02);
    chk("R5 relock p", prog_unlocked, 0); chk("R5 keep d", data_unlocked, 1);
    wreg(2, 8'h01);
    chk("R5 relock d", data_unlocked, 0);
    // R9 locked write ignored
    wreg(3, 8'h01); chk("R9 locked ignore", rop_active, 0); chk("R9 no erase", erase_req, 0);
    wreg(1, 8'hAE); wreg(1, 8'h56); wreg(0, 8'h56); wreg(0, 8'hAE);
    wreg(3, 8'h01); chk("R9 set", rop_active, 1); chk("R9 set no erase", erase_req, 0);
    sweep("R8", 1, 1, 1);
    reg_we = 1; reg_addr = 3; reg_wdata = 0;
    @(posedge clk); @(negedge clk); reg_we = 0;
    chk("R9 erase", erase_req, 1); chk("R9 cleared", rop_active, 0);
    @(negedge clk); chk("R9 erase one cycle", erase_req, 0);
    // R11 back-pressure
    boot_pages = 0; resp_ready = 0;
    req(0, 16'h0400, 1, 0, g, v);
    chk("R11 first", g, 1); chk("R11 valid", resp_valid, 1);
    req_valid = 1; req_area = 3; req_write = 1;
    @(negedge clk);
    chk("R11 stall ready", req_ready, 0);
    chk("R11 held grant", resp_grant, 1);
    chk("R11 held valid", resp_valid, 1);
    resp_ready = 1; @(posedge clk); @(negedge clk); req_valid = 0;
    chk("R11 next", resp_grant, 0); chk("R10 next viol", viol_pulse, 1);
    @(negedge clk);
    chk("R11 drained", resp_valid, 0); chk("R10 pulse ends", viol_pulse, 0);
    // R1 reset with rop_init
    rop_init = 1; rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    chk("R1 rop init", rop_active, 1); chk("R1 relocked", prog_unlocked, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule